// File: doc/BRIEF.md
# HDLC Receive Frame Length Tracker

This block follows the bytes of an incoming HDLC frame as they are written into a receive FIFO that is 32 bytes deep. It keeps a running length for the frame in progress. The length is held as a 5-bit remainder within the current FIFO load plus a 7-bit count of complete 32-byte loads. When the deframer signals end of frame, the block captures the length, a status byte and a header byte into a view that the processor reads. That view stays frozen until the processor sends a receive-complete acknowledge.

The processor reads the length through two byte-wide registers. An interrupt tells it that a frame has ended. A second interrupt tells it that another 32 bytes are ready to drain. A third reports bytes or frames that were lost. If a frame ends while the processor has not yet acknowledged the previous one, the new result waits in a single holding slot. Its interrupt is raised only once the acknowledge arrives. If a third frame ends while both the view and the slot are occupied, that frame is discarded and the loss interrupt is raised.

Top module: `hdlc_rxcnt`

## Requirements
- R1: After a synchronous reset, `cnt_lo`, `cnt_hi`, `stat_q` and `hdr_q` read zero and all three interrupt lines are low.
- R2: Once a frame has been captured, `cnt_lo[4:0]` holds the number of bytes in its final, partial 32-byte load. A byte written in the same cycle as `eof` counts as part of the frame that is ending.
- R3: The number of complete 32-byte loads before that remainder is a 7-bit value. Its three low bits sit in `cnt_lo[7:5]` and its four high bits in `cnt_hi[3:0]`, and `cnt_hi[7:4]` reads zero.
- R4: While a captured frame has not been acknowledged, `cnt_lo`, `cnt_hi`, `stat_q` and `hdr_q` do not change, whatever further bytes or frames arrive.
- R5: An `ack` with no frame waiting clears the visible count, status and header to zero. Every frame's running length starts from zero.
- R6: `irq_eom` is a one-cycle pulse in the cycle after a frame result enters an empty view. A frame that ends while the view is occupied is held back, and its pulse comes in the cycle after the `ack` that exposes it.
- R7: `irq_pool` is a one-cycle pulse in the cycle after every 32nd accepted byte of a frame.
- R8: A `byte_wr` while `fifo_full` is high is not counted, and `irq_ovf` pulses in the following cycle.
- R9: The block count saturates at 127 and does not wrap to zero. The remainder keeps counting.
- R10: An `eof` that arrives while both the view and the holding slot are occupied, with no `ack` in that cycle, discards that frame and pulses `irq_ovf` in the following cycle.
- R11: `stat_q` and `hdr_q` show the `eof_stat` and `hdr_in` values sampled with the same `eof` as the visible count, and they follow the same hold and clear rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr | input | 1 | A received byte is written to the FIFO this cycle |
| fifo_full | input | 1 | FIFO has no room; a byte written now is lost |
| eof | input | 1 | Current frame ends this cycle |
| eof_stat | input | 8 | Frame status sampled with `eof` |
| hdr_in | input | 8 | Header/address byte sampled with `eof` |
| ack | input | 1 | Processor receive-complete acknowledge |
| cnt_lo | output | 8 | {block count[2:0], remainder[4:0]} of the visible frame |
| cnt_hi | output | 8 | {4'b0, block count[6:3]} of the visible frame |
| stat_q | output | 8 | Status of the visible frame |
| hdr_q | output | 8 | Header of the visible frame |
| irq_eom | output | 1 | End-of-message interrupt pulse |
| irq_pool | output | 1 | 32-byte load ready interrupt pulse |
| irq_ovf | output | 1 | Byte or frame lost interrupt pulse |

## Verification
Short frames, frames that end exactly on a 32-byte boundary and frames that end together with their last byte test the split between remainder and block count, and the carry from one into the other. Chains of frames with the acknowledge withheld test the freeze, the one-slot deferral and the discard of a third frame. A run of more than 4096 bytes shows that the block count saturates rather than wraps. A long random mix of writes, full-FIFO writes, frame ends and acknowledges, compared each cycle against a behavioural queue model, covers cases where `ack` and `eof` fall in the same cycle.

// File: rtl/hdlc_rxcnt_pkg.sv
package hdlc_rxcnt_pkg;
  // Byte width of the processor-visible registers.
  localparam int REG_W = 8;

  // How many frame results the capture stage currently holds.
  typedef enum logic [1:0] {
    OCC_NONE = 2'd0,
    OCC_ONE  = 2'd1,
    OCC_TWO  = 2'd2
  } occ_t;
endpackage

// File: rtl/hdlc_rxcnt_run.sv
// Running length of the frame in progress: remainder plus saturating block count.
module hdlc_rxcnt_run #(
  parameter int REM_W = 5,
  parameter int BLK_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_wr,
  input  logic             fifo_full,
  input  logic             eof,
  output logic [REM_W-1:0] fin_rem,
  output logic [BLK_W-1:0] fin_blk,
  output logic             pool_hit,
  output logic             ovf_hit
);
  localparam logic [REM_W-1:0] REM_LAST = '1;
  localparam logic [BLK_W-1:0] BLK_MAX  = '1;

  logic [REM_W-1:0] rem_q;
  logic [BLK_W-1:0] blk_q;
  logic             acc;

  // Length including a byte accepted in this very cycle.
  always_comb begin
    acc      = byte_wr && !fifo_full;
    ovf_hit  = byte_wr && fifo_full;
    pool_hit = acc && (rem_q == REM_LAST);
    fin_rem  = rem_q + REM_W'(acc);
    fin_blk  = blk_q;
    if (pool_hit && (blk_q != BLK_MAX))
      fin_blk = blk_q + BLK_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || eof) begin
      rem_q <= '0;
      blk_q <= '0;
    end else begin
      rem_q <= fin_rem;
      blk_q <= fin_blk;
    end
  end
endmodule

// File: rtl/hdlc_rxcnt_hold.sv
// Two-place capture store: the visible result and one deferred result.
module hdlc_rxcnt_hold
  import hdlc_rxcnt_pkg::*;
#(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         head_vld,
  output logic         defer_vld,
  output logic         drop,
  output logic         fresh
);
  occ_t         occ_q, occ_n;
  logic [W-1:0] s0_q, s1_q, s0_n, s1_n;

  // The acknowledge is applied before a new result is stored.
  always_comb begin
    s0_n  = s0_q;
    s1_n  = s1_q;
    occ_n = occ_q;
    drop  = 1'b0;
    if (pop) begin
      case (occ_q)
        OCC_ONE: begin s0_n = '0;   occ_n = OCC_NONE; end
        OCC_TWO: begin s0_n = s1_q; occ_n = OCC_ONE;  end
        default: ;
      endcase
    end
    if (push) begin
      case (occ_n)
        OCC_NONE: begin s0_n = din; occ_n = OCC_ONE; end
        OCC_ONE:  begin s1_n = din; occ_n = OCC_TWO; end
        default:  drop = 1'b1;
      endcase
    end
    fresh = (pop || (occ_q == OCC_NONE)) && (occ_n != OCC_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= OCC_NONE;
      s0_q  <= '0;
      s1_q  <= '0;
    end else begin
      occ_q <= occ_n;
      s0_q  <= s0_n;
      s1_q  <= s1_n;
    end
  end

  assign head      = s0_q;
  assign head_vld  = (occ_q != OCC_NONE);
  assign defer_vld = (occ_q == OCC_TWO);
endmodule

// File: rtl/hdlc_rxcnt.sv
// HDLC receive frame length tracker: top level.
module hdlc_rxcnt
  import hdlc_rxcnt_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int BLK_W      = 7,
  parameter int STAT_W     = 8,
  parameter int HDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_wr,
  input  logic              fifo_full,
  input  logic              eof,
  input  logic [STAT_W-1:0] eof_stat,
  input  logic [HDR_W-1:0]  hdr_in,
  input  logic              ack,
  output logic [REG_W-1:0]  cnt_lo,
  output logic [REG_W-1:0]  cnt_hi,
  output logic [STAT_W-1:0] stat_q,
  output logic [HDR_W-1:0]  hdr_q,
  output logic              irq_eom,
  output logic              irq_pool,
  output logic              irq_ovf
);
  localparam int REM_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = REM_W + BLK_W;
  localparam int MSG_W = CNT_W + STAT_W + HDR_W;

  logic [REM_W-1:0]   fin_rem;
  logic [BLK_W-1:0]   fin_blk;
  logic               pool_hit, ovf_hit;
  logic [MSG_W-1:0]   msg_in, head;
  logic               head_vld, defer_vld, drop, fresh;
  logic [CNT_W-1:0]   head_cnt;
  logic [2*REG_W-1:0] cnt_wide;

  hdlc_rxcnt_run #(.REM_W(REM_W), .BLK_W(BLK_W)) u_run (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .fifo_full(fifo_full), .eof(eof),
    .fin_rem(fin_rem), .fin_blk(fin_blk), .pool_hit(pool_hit), .ovf_hit(ovf_hit)
  );

  assign msg_in = {fin_blk, fin_rem, eof_stat, hdr_in};

  hdlc_rxcnt_hold #(.W(MSG_W)) u_hold (
    .clk(clk), .rst(rst), .push(eof), .pop(ack), .din(msg_in),
    .head(head), .head_vld(head_vld), .defer_vld(defer_vld),
    .drop(drop), .fresh(fresh)
  );

  // Visible registers come straight from the store's flops.
  assign head_cnt = head[MSG_W-1 -: CNT_W];
  assign cnt_wide = (2*REG_W)'(head_cnt);
  assign cnt_lo   = cnt_wide[REG_W-1:0];
  assign cnt_hi   = cnt_wide[2*REG_W-1:REG_W];
  assign stat_q   = head[HDR_W +: STAT_W];
  assign hdr_q    = head[HDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_eom  <= 1'b0;
      irq_pool <= 1'b0;
      irq_ovf  <= 1'b0;
    end else begin
      irq_eom  <= fresh;
      irq_pool <= pool_hit;
      irq_ovf  <= ovf_hit || drop;
    end
  end
endmodule

// File: rtl/hdlc_rxcnt_chk.sv
module hdlc_rxcnt_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_wr,
  input logic       fifo_full,
  input logic       eof,
  input logic       ack,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic [7:0] stat_q,
  input logic [7:0] hdr_q,
  input logic       irq_eom,
  input logic       irq_pool,
  input logic       irq_ovf,
  input logic       head_vld,
  input logic       defer_vld
);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (head_vld && !ack) |=> ($stable(cnt_lo) && $stable(cnt_hi) && $stable(stat_q) && $stable(hdr_q)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && !defer_vld && !eof) |=> (cnt_lo == 8'd0 && cnt_hi == 8'd0 && stat_q == 8'd0 && hdr_q == 8'd0));

  p_eom_valid_r6: assert property (@(posedge clk) disable iff (rst)
    irq_eom |-> head_vld);

  p_defer_r6: assert property (@(posedge clk) disable iff (rst)
    (eof && head_vld && !ack) |=> !irq_eom);

  p_pool_src_r7: assert property (@(posedge clk) disable iff (rst)
    irq_pool |-> $past(byte_wr && !fifo_full));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (byte_wr && fifo_full) |=> irq_ovf);

  p_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (eof && defer_vld && !ack) |=> irq_ovf);
endmodule

bind hdlc_rxcnt hdlc_rxcnt_chk u_chk (
  .clk(clk), .rst(rst), .byte_wr(byte_wr), .fifo_full(fifo_full), .eof(eof),
  .ack(ack), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .stat_q(stat_q), .hdr_q(hdr_q),
  .irq_eom(irq_eom), .irq_pool(irq_pool), .irq_ovf(irq_ovf),
  .head_vld(head_vld), .defer_vld(defer_vld)
);

// File: tb/tb_hdlc_rxcnt.sv
`timescale 1ns/1ps
module tb_hdlc_rxcnt;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_wr = 1'b0, fifo_full = 1'b0, eof = 1'b0, ack = 1'b0;
  logic [7:0] eof_stat = 8'd0, hdr_in = 8'd0;
  logic [7:0] cnt_lo, cnt_hi, stat_q, hdr_q;
  logic       irq_eom, irq_pool, irq_ovf;

  int nchk = 0, nerr = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hdlc_rxcnt dut (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .fifo_full(fifo_full), .eof(eof),
    .eof_stat(eof_stat), .hdr_in(hdr_in), .ack(ack),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .stat_q(stat_q), .hdr_q(hdr_q),
    .irq_eom(irq_eom), .irq_pool(irq_pool), .irq_ovf(irq_ovf)
  );

  // Behavioural reference: running length plus a queue of frame results.
  int m_rem = 0, m_blk = 0;
  int q_cnt[$], q_st[$], q_hd[$];
  int e_lo = 0, e_hi = 0, e_st = 0, e_hd = 0;
  int e_eom = 0, e_pool = 0, e_ovf = 0;

  always @(posedge clk) begin
    int fr, fb, cnt;
    bit had;
    started = 1;
    e_eom = 0; e_pool = 0; e_ovf = 0;
    if (rst) begin
      m_rem = 0; m_blk = 0;
      q_cnt.delete(); q_st.delete(); q_hd.delete();
    end else begin
      had = (q_cnt.size() > 0);
      if (byte_wr && fifo_full) e_ovf = 1;
      fr = m_rem + ((byte_wr && !fifo_full) ? 1 : 0);
      fb = m_blk;
      if (fr == 32) begin
        fr = 0; e_pool = 1;
        if (fb < 127) fb++;
      end
      if (eof) begin m_rem = 0; m_blk = 0; end
      else begin m_rem = fr; m_blk = fb; end
      if (ack && q_cnt.size() > 0) begin
        void'(q_cnt.pop_front()); void'(q_st.pop_front()); void'(q_hd.pop_front());
      end
      if (eof) begin
        if (q_cnt.size() < 2) begin
          q_cnt.push_back(fb * 32 + fr); q_st.push_back(eof_stat); q_hd.push_back(hdr_in);
        end else e_ovf = 1;
      end
      e_eom = ((ack || !had) && q_cnt.size() > 0) ? 1 : 0;
    end
    if (q_cnt.size() > 0) begin
      cnt = q_cnt[0];
      e_lo = cnt % 256; e_hi = cnt / 256; e_st = q_st[0]; e_hd = q_hd[0];
    end else begin
      e_lo = 0; e_hi = 0; e_st = 0; e_hd = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 cnt_lo", cnt_lo, e_lo);
      chk("R3 cnt_hi", cnt_hi, e_hi);
      chk("R11 stat_q", stat_q, e_st);
      chk("R11 hdr_q", hdr_q, e_hd);
      chk("R6 irq_eom", irq_eom, e_eom);
      chk("R7 irq_pool", irq_pool, e_pool);
      chk("R8 irq_ovf", irq_ovf, e_ovf);
    end
  end

  task automatic step(bit bw, bit ff, bit e, bit a, logic [7:0] st = 8'd0, logic [7:0] hd = 8'd0);
    @(posedge clk); #1;
    byte_wr = bw; fifo_full = ff; eof = e; ack = a; eof_stat = st; hdr_in = hd;
  endtask

  task automatic idle_obs();
    step(0, 0, 0, 0);
    @(negedge clk);
  endtask

  // n bytes; the last one shares its cycle with eof when joint is set.
  task automatic frame(int n, logic [7:0] st, logic [7:0] hd, bit joint);
    for (int i = 0; i < n; i++) begin
      if (joint && i == n - 1) step(1, 0, 1, 0, st, hd);
      else step(1, 0, 0, 0);
    end
    if (!joint) step(0, 0, 1, 0, st, hd);
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 cnt_lo", cnt_lo, 0); chk("R1 cnt_hi", cnt_hi, 0);
    chk("R1 stat", stat_q, 0);   chk("R1 hdr", hdr_q, 0);
    chk("R1 irqs", {irq_eom, irq_pool, irq_ovf}, 0);
    @(posedge clk); #1; rst = 0;

    // Short frame
    frame(5, 8'h81, 8'h3C, 0);
    idle_obs();
    chk("R2 remainder 5", cnt_lo, 5);
    chk("R3 no blocks", cnt_hi, 0);
    chk("R6 eom pulse", irq_eom, 1);
    chk("R11 status", stat_q, 8'h81);
    chk("R11 header", hdr_q, 8'h3C);
    frame(9, 8'h11, 8'h22, 0);
    idle_obs();
    chk("R4 held count", cnt_lo, 5);
    chk("R4 held status", stat_q, 8'h81);
    chk("R6 deferred no pulse", irq_eom, 0);
    step(0, 0, 0, 1);
    idle_obs();
    chk("R6 deferred pulse", irq_eom, 1);
    chk("R5 fresh count", cnt_lo, 9);
    step(0, 0, 0, 1);
    idle_obs();
    chk("R5 ack clears lo", cnt_lo, 0);
    chk("R5 ack clears stat", stat_q, 0);

    // 70 bytes, last one with eof: 2 blocks + 6
    frame(70, 8'h05, 8'h06, 1);
    idle_obs();
    chk("R2 joint byte counted", cnt_lo, 8'h46);
    chk("R3 hi zero", cnt_hi, 0);
    step(0, 0, 0, 1);

    // Exactly 32 bytes
    for (int i = 0; i < 32; i++) step(1, 0, 0, 0);
    idle_obs();
    chk("R7 pool pulse", irq_pool, 1);
    step(0, 0, 1, 0, 8'h07, 8'h08);
    idle_obs();
    chk("R3 one block rem 0", cnt_lo, 8'h20);
    step(0, 0, 0, 1);

    // Full FIFO byte not counted
    step(1, 0, 0, 0); step(1, 1, 0, 0);
    idle_obs();
    chk("R8 ovf pulse", irq_ovf, 1);
    step(1, 0, 0, 0); step(0, 0, 1, 0, 8'h09, 8'h0A);
    idle_obs();
    chk("R8 byte not counted", cnt_lo, 2);
    step(0, 0, 0, 1);

    // Three frames without ack
    frame(2, 8'hA1, 8'hB1, 0);
    frame(4, 8'hA2, 8'hB2, 0);
    frame(1, 8'hA3, 8'hB3, 0);
    idle_obs();
    chk("R10 drop ovf", irq_ovf, 1);
    chk("R4 first still shown", cnt_lo, 2);
    step(0, 0, 0, 1);
    idle_obs();
    chk("R6 second shown", cnt_lo, 4);
    chk("R11 second status", stat_q, 8'hA2);
    step(0, 0, 0, 1);
    idle_obs();
    chk("R10 third discarded", cnt_lo, 0);
    chk("R10 no eom", irq_eom, 0);

    // Saturation: 4200 bytes = 131 blocks + 8
    frame(4200, 8'h55, 8'h66, 0);
    idle_obs();
    chk("R9 saturated lo", cnt_lo, 8'hE8);
    chk("R9 saturated hi", cnt_hi, 8'h0F);
    step(0, 0, 0, 1);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) < 6, ($urandom % 10) == 0, ($urandom % 32) == 0,
           ($urandom % 20) == 0, 8'($urandom), 8'($urandom));
    end
    step(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule